// File: doc/BRIEF.md
# Reset-Addressed Serial Field Memory

This block is a dual-port store for a stream of video samples that has no address inputs. The writer and the reader each own one pointer. A pointer moves only in two ways: a reset on its own port sets it to zero, and each enabled clock edge on that port moves it forward by one. A stream written after a write reset therefore comes back in the same order after a read reset. Each pointer wraps to zero after the last location, so the store behaves as a circular field buffer.

The write side and the read side each run on their own clock and are not related in phase or frequency. The writer can fill a field while the reader plays back an earlier one. A location that the writer is updating close in time to the reader may return either the earlier or the later word. A location that is well clear of the writer returns a known word. A build-time option delays input capture by one write clock. With that option, two units that share control lines can be chained to act as one store of twice the depth.

Top module: `fieldmem_serial`

## Requirements
- R1: A write clock edge with the write reset high and the write enable low sets the write pointer to 0. After that, each edge with the write enable high stores the data word at the pointer and then moves the pointer to the next address.
- R2: After a read reset, enabled read edges return the stored words starting at address 0 and in rising address order, which is the order they were written.
- R3: An edge with the enable low and the reset low leaves that port's pointer unchanged. On the write side nothing is stored, whatever value is on the data input.
- R4: Read data updates at the enabled read edge itself, so it is visible one read clock after the enable is presented. It keeps its value on every read edge where the read enable is low.
- R5: After address DEPTH-1, each pointer wraps to address 0. A write pass longer than DEPTH overwrites the oldest words.
- R6: When a reset and an enable are high on the same edge, that access uses address 0 and the pointer moves on to address 1.
- R7: With CASCADE=1, the word stored at an enabled write edge is the data input value from the write edge before it. With CASCADE=0, it is the value at the same edge.
- R8: While the two ports run on unrelated clocks, a location the writer has already overwritten in the current pass reads back as the new word. A location the writer has not yet reached reads back as the word from the previous pass.
- R9: A new read reset replays the field from address 0. Reading does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Write pointer reset to address 0, sampled on wr_clk |
| wr_en | input | 1 | Write enable: store a word and advance the pointer |
| wr_data | input | DATA_W | Sample to store |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Read pointer reset to address 0, sampled on rd_clk |
| rd_en | input | 1 | Read enable: fetch a word and advance the pointer |
| rd_data | output | DATA_W | Registered read word, held while reading is idle |

## Verification
The bench builds two instances with DEPTH=16 and DATA_W=8 that share every input. One has CASCADE=0 and the other has CASCADE=1. The small depth lets a write pass go past the last address, so wrap-around and overwriting of the oldest words are checked in a short run. Because both instances see the same stimulus, the one-clock capture shift can be compared directly against the undelayed path. The write clock runs at 10 ns and the read clock at 14 ns. This places the two pointers far apart, so old-versus-new results can be stated with certainty.

// File: rtl/fieldmem_pkg.sv
package fieldmem_pkg;

  // What a port does on one of its clock edges.
  typedef enum logic [1:0] {
    ACC_IDLE         = 2'd0,
    ACC_STEP         = 2'd1,
    ACC_RESTART      = 2'd2,
    ACC_RESTART_STEP = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic restart, input logic step);
    acc_kind_e k;
    if (restart && step)   k = ACC_RESTART_STEP;
    else if (restart)      k = ACC_RESTART;
    else if (step)         k = ACC_STEP;
    else                   k = ACC_IDLE;
    return k;
  endfunction

  // Next address on a circular store whose final index is last.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned last);
    int unsigned r;
    if (p >= last) r = 0;
    else           r = p + 1;
    return r;
  endfunction

endpackage

// File: rtl/fieldmem_ptr.sv
module fieldmem_ptr #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          restart,
  input  logic          step,
  output logic          fire,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ptr
);
  import fieldmem_pkg::*;

  localparam int unsigned LAST = DEPTH - 1;

  acc_kind_e     kind;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_next;

  always_comb begin
    kind     = classify(restart, step);
    // A reset in the same cycle redirects this access to location 0.
    addr     = (kind == ACC_RESTART || kind == ACC_RESTART_STEP) ? '0 : ptr_q;
    ptr_next = AW'(wrap_inc(32'(addr), LAST));
    fire     = step;
  end

  always_ff @(posedge clk) begin
    unique case (kind)
      ACC_IDLE:         ptr_q <= ptr_q;
      ACC_RESTART:      ptr_q <= '0;
      ACC_STEP,
      ACC_RESTART_STEP: ptr_q <= ptr_next;
      default:          ptr_q <= ptr_q;
    endcase
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/fieldmem_capture.sv
module fieldmem_capture #(
  parameter int DATA_W  = 8,
  parameter bit CASCADE = 1'b0
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] word
);
  generate
    if (CASCADE) begin : g_delayed
      logic [DATA_W-1:0] hold_q;
      // Sampled on every edge, so the stored word lags the input by one clock.
      always_ff @(posedge clk) hold_q <= din;
      assign word = hold_q;
    end else begin : g_direct
      assign word = din;
    end
  endgenerate

endmodule

// File: rtl/fieldmem_store.sv
module fieldmem_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata_q <= cells[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/fieldmem_serial.sv
module fieldmem_serial #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter bit CASCADE = 1'b0
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  // Per-port events, brought out by name for the checker.
  logic              w_fire;
  logic [AW-1:0]     w_addr;
  logic [AW-1:0]     w_ptr;
  logic [DATA_W-1:0] w_word;
  logic              r_fire;
  logic [AW-1:0]     r_addr;
  logic [AW-1:0]     r_ptr;

  fieldmem_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk     (wr_clk),
    .restart (wr_rst),
    .step    (wr_en),
    .fire    (w_fire),
    .addr    (w_addr),
    .ptr     (w_ptr)
  );

  fieldmem_capture #(.DATA_W(DATA_W), .CASCADE(CASCADE)) u_cap (
    .clk  (wr_clk),
    .din  (wr_data),
    .word (w_word)
  );

  fieldmem_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk     (rd_clk),
    .restart (rd_rst),
    .step    (rd_en),
    .fire    (r_fire),
    .addr    (r_addr),
    .ptr     (r_ptr)
  );

  fieldmem_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .wclk  (wr_clk),
    .we    (w_fire),
    .waddr (w_addr),
    .wdata (w_word),
    .rclk  (rd_clk),
    .re    (r_fire),
    .raddr (r_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/fieldmem_serial_chk.sv
module fieldmem_serial_chk #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter bit CASCADE = 1'b0
) (
  input logic                       wr_clk,
  input logic                       wr_rst,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       rd_clk,
  input logic                       rd_rst,
  input logic                       rd_en,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       w_fire,
  input logic [$clog2(DEPTH)-1:0]   w_ptr,
  input logic [DATA_W-1:0]          w_word,
  input logic [$clog2(DEPTH)-1:0]   r_ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam int unsigned LAST = DEPTH - 1;

  // Pointers are only meaningful once their own reset has been seen.
  logic w_armed = 1'b0;
  logic r_armed = 1'b0;
  logic r_live  = 1'b0;

  always_ff @(posedge wr_clk) if (wr_rst) w_armed <= 1'b1;
  always_ff @(posedge rd_clk) if (rd_rst) r_armed <= 1'b1;
  always_ff @(posedge rd_clk) if (r_armed && rd_en) r_live <= 1'b1;

  AST_WPTR_CLEAR: assert property (@(posedge wr_clk) disable iff (!w_armed)
    wr_rst && !wr_en |=> w_ptr == '0);                                       // R1
  AST_WPTR_STEP: assert property (@(posedge wr_clk) disable iff (!w_armed)
    !wr_rst && wr_en |=> w_ptr == AW'(fieldmem_pkg::wrap_inc(32'($past(w_ptr)), LAST))); // R1
  AST_WPTR_IDLE: assert property (@(posedge wr_clk) disable iff (!w_armed)
    !wr_rst && !wr_en |=> $stable(w_ptr));                                   // R3
  AST_WPTR_WRAP: assert property (@(posedge wr_clk) disable iff (!w_armed)
    !wr_rst && wr_en && w_ptr == AW'(LAST) |=> w_ptr == '0);                  // R5
  AST_WRST_WITH_EN: assert property (@(posedge wr_clk) disable iff (!w_armed)
    wr_rst && wr_en |=> w_ptr == AW'(1));                                    // R6
  AST_RPTR_CLEAR: assert property (@(posedge rd_clk) disable iff (!r_armed)
    rd_rst && !rd_en |=> r_ptr == '0);                                       // R2
  AST_RPTR_IDLE: assert property (@(posedge rd_clk) disable iff (!r_armed)
    !rd_rst && !rd_en |=> $stable(r_ptr));                                   // R3
  AST_RPTR_WRAP: assert property (@(posedge rd_clk) disable iff (!r_armed)
    !rd_rst && rd_en && r_ptr == AW'(LAST) |=> r_ptr == '0);                  // R5
  AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!r_live)
    !rd_en |=> $stable(rd_data));                                            // R4

  generate
    if (CASCADE) begin : g_casc_chk
      AST_CASCADE_LAG: assert property (@(posedge wr_clk) disable iff (!w_armed)
        w_fire |-> w_word == $past(wr_data));                                // R7
    end
  endgenerate

endmodule

bind fieldmem_serial fieldmem_serial_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CASCADE(CASCADE)
) u_chk (.*);

// File: tb/fieldmem_serial_bench.sv
module fieldmem_serial_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b0;
  logic          wr_en  = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_rst = 1'b0;
  logic          rd_en  = 1'b0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] rd_data_c;

  int n_checks = 0;
  int n_fails  = 0;
  int wcount   = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  fieldmem_serial #(.DATA_W(DW), .DEPTH(DEPTH), .CASCADE(1'b0)) u_fieldmem_serial (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data)
  );

  fieldmem_serial #(.DATA_W(DW), .DEPTH(DEPTH), .CASCADE(1'b1)) u_fieldmem_serial_casc (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data_c)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cycle(input logic rst, input logic en, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_rst = rst; wr_en = en; wr_data = d;
  endtask

  task automatic rd_cycle(input logic rst, input logic en);
    @(negedge rd_clk);
    rd_rst = rst; rd_en = en;
  endtask

  // One enabled read; the word is sampled one read clock later.
  task automatic rd_word(input logic rst, output logic [DW-1:0] d, output logic [DW-1:0] dc);
    rd_cycle(rst, 1'b1);
    @(negedge rd_clk);
    d = rd_data; dc = rd_data_c;
    rd_rst = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_basic;
    logic [DW-1:0] d, dc, keep;
    wr_cycle(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 10; i++) wr_cycle(1'b0, 1'b1, 8'h30 + DW'(i));
    wr_cycle(1'b0, 1'b0, 8'h00);
    rd_cycle(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      rd_word(1'b0, d, dc);
      check("R1/R2 in-order readback", d, 8'h30 + DW'(i));
    end
    keep = rd_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk);
      check("R4 hold while read idle", rd_data, keep);
    end
  endtask

  task automatic t_gap;
    logic [DW-1:0] d, dc;
    wr_cycle(1'b1, 1'b0, 8'h00);
    wr_cycle(1'b0, 1'b1, 8'h10);
    for (int i = 0; i < 3; i++) wr_cycle(1'b0, 1'b0, 8'hEE);
    wr_cycle(1'b0, 1'b1, 8'h11);
    wr_cycle(1'b0, 1'b0, 8'h00);
    rd_cycle(1'b1, 1'b0);
    rd_word(1'b0, d, dc);
    check("R3 first word", d, 8'h10);
    rd_cycle(1'b0, 1'b0);
    rd_cycle(1'b0, 1'b0);
    check("R3 idle read keeps output", rd_data, 8'h10);
    rd_word(1'b0, d, dc);
    check("R3 disabled write skipped", d, 8'h11);
  endtask

  task automatic t_wrap;
    logic [DW-1:0] d, dc, e;
    wr_cycle(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH + 3; i++) wr_cycle(1'b0, 1'b1, 8'h40 + DW'(i));
    wr_cycle(1'b0, 1'b0, 8'h00);
    rd_cycle(1'b1, 1'b0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      rd_word(1'b0, d, dc);
      if ((i % DEPTH) < 3) e = 8'h40 + DW'(DEPTH + (i % DEPTH));
      else                 e = 8'h40 + DW'(i);
      check("R5 wrap and overwrite", d, e);
    end
  endtask

  task automatic t_rst_en;
    logic [DW-1:0] d, dc;
    wr_cycle(1'b1, 1'b1, 8'h77);
    wr_cycle(1'b0, 1'b1, 8'h78);
    wr_cycle(1'b0, 1'b0, 8'h00);
    rd_word(1'b1, d, dc);
    check("R6 reset+read uses address 0", d, 8'h77);
    rd_word(1'b0, d, dc);
    check("R6 pointer moved to 1", d, 8'h78);
  endtask

  task automatic t_replay;
    logic [DW-1:0] d, dc;
    rd_word(1'b1, d, dc);
    check("R9 replay word 0", d, 8'h77);
    rd_word(1'b0, d, dc);
    check("R9 replay word 1", d, 8'h78);
  endtask

  task automatic t_cascade;
    logic [DW-1:0] d, dc;
    wr_cycle(1'b1, 1'b0, 8'h90);
    for (int i = 1; i <= 4; i++) wr_cycle(1'b0, 1'b1, 8'h90 + DW'(i));
    wr_cycle(1'b0, 1'b0, 8'h00);
    rd_cycle(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rd_word(1'b0, d, dc);
      check("R7 cascade lags one clock", dc, 8'h90 + DW'(i));
      check("R7 normal capture same clock", d, 8'h91 + DW'(i));
    end
  endtask

  task automatic t_async;
    logic [DW-1:0] d, dc;
    wr_cycle(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH; i++) wr_cycle(1'b0, 1'b1, 8'hA0 + DW'(i));
    wr_cycle(1'b0, 1'b0, 8'h00);
    wcount = 0;
    fork
      begin
        wr_cycle(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 8; i++) begin
          wr_cycle(1'b0, 1'b1, 8'hD0 + DW'(i));
          wcount = i + 1;
        end
        wr_cycle(1'b0, 1'b0, 8'h00);
      end
      begin
        wait (wcount >= 4);
        for (int i = 0; i < DEPTH; i++) begin
          rd_word(i == 0, d, dc);
          if (i < 8) check("R8 new data behind writer", d, 8'hD0 + DW'(i));
          else       check("R8 old data ahead of writer", d, 8'hA0 + DW'(i));
        end
      end
    join
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog R1..: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    t_basic();
    t_gap();
    t_wrap();
    t_rst_en();
    t_replay();
    t_cascade();
    t_async();
    repeat (4) @(negedge rd_clk);
    summary();
    $finish;
  end

endmodule